// File: doc/BRIEF.md
# Inter-processor interrupt command unit

This block holds the 64-bit command register a processor uses to send an interrupt to other processors. The register is written as two 32-bit words. The high word carries the destination identifier. Writing the low word both stores the command fields and launches the command. The unit checks the command before it sends anything.

A command that passes the checks is turned into a single outgoing message. The message carries the vector, the delivery mode, the trigger, the level and the resolved destination. It is offered on a valid/ready handshake. A read-only busy bit in the low word stays set from the launch until the receiver accepts the message. While that bit is set, further low-word writes are dropped. A command that fails the checks sets an error flag, and no message is sent.

The vector, trigger and destination rules differ by delivery mode and by destination shorthand. The unit resolves all of them, so the receiving fabric gets a final message and never has to interpret the raw fields.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset, `lo_o`, `hi_o`, `err_o` and `msg_valid_o` are all zero.
- R2: Low-word layout:
  - bits 7:0 are the vector, 10:8 the delivery mode and 11 the destination mode (1 = logical);
  - bit 12 is the busy status, bit 14 the level (1 = assert), bit 15 the trigger (1 = level-triggered), and bits 19:18 the shorthand;
  - bit 12 cannot be written and reads as the busy state; every other unlisted bit reads 0;
  - in the high word, only bits 31:24 are stored.
- R3: The shorthand resolves the destination as follows:
  - 00: destination comes from the high word;
  - 01: destination is `self_id_i` only;
  - 10: broadcast to all, with destination 0xFF;
  - 11: same as 10, with `msg_excl_self_o` set.
- R4: With shorthand 00, physical mode (bit 11 = 0) sends only high-word bits 27:24, and the upper four destination bits are zero. Logical mode sends all of bits 31:24.
- R5: Delivery modes 011 and 111 are reserved. Launching one sets `err_o` and sends no message.
- R6: Trigger by delivery mode:
  - fixed (000), SMI (010), NMI (100), start-up (110) and asserting INIT (101 with level 1) are sent with trigger 0 (edge);
  - lowest priority (001) sends the written trigger bit.
- R7: A level-0 (deassert) command is valid only as INIT with trigger 1. It is then sent with level 0 and trigger 1. Any other level-0 command sets `err_o` and sends nothing.
- R8: The vector is sent as 0 for SMI, NMI and INIT. It is sent unchanged for fixed, lowest priority and start-up.
- R9: On a valid launch, `msg_valid_o` and the busy bit rise one cycle after the write. They stay high, with every message field stable, until the cycle in which `msg_ready_i` is high.
- R10: A low-word write while busy is ignored: the low-word readback, `err_o` and the message are unchanged.
- R11: After acceptance, `msg_valid_o` stays low until the next low-word launch. There is no automatic resend.
- R12: Every accepted low-word write (that is, one made while not busy) sets `err_o` to the result of its own check. A valid command therefore clears an earlier error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_hi_i | input | 1 | 1 selects the high word, 0 the low (launching) word |
| wr_data_i | input | 32 | Write data |
| self_id_i | input | ID_W | This processor's identifier, used for self shorthand |
| lo_o | output | 32 | Low-word readback with busy status in bit 12 |
| hi_o | output | 32 | High-word readback |
| err_o | output | 1 | Last launched command was rejected |
| msg_valid_o | output | 1 | Outgoing message valid (busy) |
| msg_ready_i | input | 1 | Receiver accepts the message |
| msg_vector_o | output | 8 | Message vector |
| msg_mode_o | output | 3 | Message delivery mode |
| msg_logical_o | output | 1 | Destination is a logical address |
| msg_level_o | output | 1 | 1 assert, 0 deassert |
| msg_trig_o | output | 1 | 1 level-triggered, 0 edge |
| msg_dest_o | output | ID_W | Resolved destination |
| msg_bcast_o | output | 1 | Broadcast to all processors |
| msg_excl_self_o | output | 1 | Broadcast excludes the sender |

## Verification
The bench sweeps every combination of delivery mode, level, trigger, shorthand and destination mode. It predicts each message from the stated rules.

- A design that took the physical destination from all eight high bits would show garbage in the upper nibble.
- A design that forwarded the vector for SMI, NMI or INIT would leak it.
- A design that accepted level deassert outside INIT would send a message where an error is expected.

The bench also stalls the handshake and writes the low word mid-flight. A unit that latched that write would corrupt the readback or the in-flight message. A unit that re-armed itself after acceptance would raise `msg_valid_o` a second time.

// File: rtl/ipi_cmd_pkg.sv
package ipi_cmd_pkg;
  typedef enum logic [2:0] {
    DM_FIXED  = 3'b000,
    DM_LOWPRI = 3'b001,
    DM_SMI    = 3'b010,
    DM_RSV3   = 3'b011,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_START  = 3'b110,
    DM_RSV7   = 3'b111
  } dmode_e;

  typedef enum logic [1:0] {
    SH_FIELD  = 2'b00,
    SH_SELF   = 2'b01,
    SH_ALL    = 2'b10,
    SH_OTHERS = 2'b11
  } short_e;

  typedef struct packed {
    short_e     sh;
    logic       trig;
    logic       level;
    logic       logical;
    dmode_e     mode;
    logic [7:0] vec;
  } cmd_t;

  // low-word field positions
  localparam int VEC_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int LOG_BIT  = 11;
  localparam int BUSY_BIT = 12;
  localparam int LVL_BIT  = 14;
  localparam int TRG_BIT  = 15;
  localparam int SH_LSB   = 18;
  localparam logic [31:0] LO_MASK = 32'h000C_CFFF;
endpackage

// File: rtl/ipi_cmd_regs.sv
module ipi_cmd_regs #(
  parameter int ID_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] data_i,
  output logic [31:0] lo_next_o,
  output logic [31:0] lo_q_o,
  output logic [31:0] hi_q_o
);
  import ipi_cmd_pkg::*;
  localparam logic [31:0] HI_MASK = ~(32'hFFFF_FFFF >> ID_W);

  assign lo_next_o = data_i & LO_MASK;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q_o <= '0;
      hi_q_o <= '0;
    end else begin
      if (wr_lo_i) lo_q_o <= lo_next_o;
      if (wr_hi_i) hi_q_o <= data_i & HI_MASK;
    end
  end
endmodule

// File: rtl/ipi_cmd_check.sv
module ipi_cmd_check
  import ipi_cmd_pkg::*;
(
  input  cmd_t       cmd_i,
  output logic       ok_o,
  output logic [7:0] vec_o,
  output logic       level_o,
  output logic       trig_o
);
  logic rsv, deassert_ok;

  always_comb begin
    rsv         = (cmd_i.mode == DM_RSV3) || (cmd_i.mode == DM_RSV7);
    deassert_ok = cmd_i.level || (cmd_i.mode == DM_INIT && cmd_i.trig);
    ok_o        = !rsv && deassert_ok;
    level_o     = cmd_i.level;
    unique case (cmd_i.mode)
      DM_SMI, DM_NMI, DM_INIT: vec_o = '0;
      default:                 vec_o = cmd_i.vec;
    endcase
    unique case (cmd_i.mode)
      DM_LOWPRI: trig_o = cmd_i.trig;
      DM_INIT:   trig_o = !cmd_i.level;  // only a deassert travels as level
      default:   trig_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ipi_dest_resolve.sv
module ipi_dest_resolve
  import ipi_cmd_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int PHYS_W = 4
) (
  input  short_e            sh_i,
  input  logic              logical_i,
  input  logic [ID_W-1:0]   field_i,
  input  logic [ID_W-1:0]   self_id_i,
  output logic [ID_W-1:0]   dest_o,
  output logic              bcast_o,
  output logic              excl_self_o
);
  logic [ID_W-1:0] field_eff;

  generate
    if (PHYS_W < ID_W) begin : g_narrow
      assign field_eff = logical_i ? field_i
                                   : {{(ID_W-PHYS_W){1'b0}}, field_i[PHYS_W-1:0]};
    end else begin : g_full
      assign field_eff = field_i;
    end
  endgenerate

  always_comb begin
    bcast_o     = sh_i[1];
    excl_self_o = (sh_i == SH_OTHERS);
    unique case (sh_i)
      SH_FIELD: dest_o = field_eff;
      SH_SELF:  dest_o = self_id_i;
      default:  dest_o = '1;
    endcase
  end
endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_cmd_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int PHYS_W = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            wr_hi_i,
  input  logic [31:0]     wr_data_i,
  input  logic [ID_W-1:0] self_id_i,
  output logic [31:0]     lo_o,
  output logic [31:0]     hi_o,
  output logic            err_o,
  output logic            msg_valid_o,
  input  logic            msg_ready_i,
  output logic [7:0]      msg_vector_o,
  output logic [2:0]      msg_mode_o,
  output logic            msg_logical_o,
  output logic            msg_level_o,
  output logic            msg_trig_o,
  output logic [ID_W-1:0] msg_dest_o,
  output logic            msg_bcast_o,
  output logic            msg_excl_self_o
);
  localparam int DEST_LSB = 32 - ID_W;

  logic        busy_q, err_q;
  logic        wr_lo, launch, ok;
  logic [31:0] lo_next, lo_q, hi_q;
  cmd_t        cmd;
  logic [7:0]  vec_n;
  logic        lvl_n, trg_n;
  logic [ID_W-1:0] dest_n;
  logic        bc_n, ex_n;

  assign wr_lo  = wr_en_i && !wr_hi_i && !busy_q;
  assign launch = wr_lo && ok;

  ipi_cmd_regs #(.ID_W(ID_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (wr_lo),
    .wr_hi_i   (wr_en_i && wr_hi_i),
    .data_i    (wr_data_i),
    .lo_next_o (lo_next),
    .lo_q_o    (lo_q),
    .hi_q_o    (hi_q)
  );

  always_comb begin
    cmd.vec     = lo_next[VEC_LSB +: 8];
    cmd.mode    = dmode_e'(lo_next[MODE_LSB +: 3]);
    cmd.logical = lo_next[LOG_BIT];
    cmd.level   = lo_next[LVL_BIT];
    cmd.trig    = lo_next[TRG_BIT];
    cmd.sh      = short_e'(lo_next[SH_LSB +: 2]);
  end

  ipi_cmd_check u_check (
    .cmd_i   (cmd),
    .ok_o    (ok),
    .vec_o   (vec_n),
    .level_o (lvl_n),
    .trig_o  (trg_n)
  );

  ipi_dest_resolve #(.ID_W(ID_W), .PHYS_W(PHYS_W)) u_dest (
    .sh_i        (cmd.sh),
    .logical_i   (cmd.logical),
    .field_i     (hi_q[DEST_LSB +: ID_W]),
    .self_id_i   (self_id_i),
    .dest_o      (dest_n),
    .bcast_o     (bc_n),
    .excl_self_o (ex_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q          <= 1'b0;
      err_q           <= 1'b0;
      msg_vector_o    <= '0;
      msg_mode_o      <= '0;
      msg_logical_o   <= 1'b0;
      msg_level_o     <= 1'b0;
      msg_trig_o      <= 1'b0;
      msg_dest_o      <= '0;
      msg_bcast_o     <= 1'b0;
      msg_excl_self_o <= 1'b0;
    end else begin
      if (wr_lo) err_q <= !ok;
      if (launch) begin
        busy_q          <= 1'b1;
        msg_vector_o    <= vec_n;
        msg_mode_o      <= cmd.mode;
        msg_logical_o   <= cmd.logical;
        msg_level_o     <= lvl_n;
        msg_trig_o      <= trg_n;
        msg_dest_o      <= dest_n;
        msg_bcast_o     <= bc_n;
        msg_excl_self_o <= ex_n;
      end else if (busy_q && msg_ready_i) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign msg_valid_o = busy_q;
  assign err_o       = err_q;
  assign hi_o        = hi_q;
  assign lo_o        = lo_q | (32'(busy_q) << BUSY_BIT);

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_dest_o)
      && $stable(msg_vector_o) && $stable(msg_mode_o) && $stable(msg_trig_o));

  p_once_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_ready_i |=> !msg_valid_o);

  p_ignore_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |=> $stable(lo_o[31:13]) && $stable(lo_o[11:0]) && $stable(err_o));

  p_no_rsv_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_mode_o != DM_RSV3 && msg_mode_o != DM_RSV7);

  p_edge_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_mode_o == DM_FIXED || msg_mode_o == DM_SMI ||
                    msg_mode_o == DM_NMI || msg_mode_o == DM_START) |-> !msg_trig_o);

  p_deassert_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_level_o |-> msg_mode_o == DM_INIT && msg_trig_o);

  p_vec_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && (msg_mode_o == DM_SMI || msg_mode_o == DM_NMI ||
                    msg_mode_o == DM_INIT) |-> msg_vector_o == '0);

  p_bcast_dest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && msg_bcast_o |-> msg_dest_o == '1);
endmodule

// File: tb/tb_ipi_cmd_unit.sv
module tb_ipi_cmd_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, wr_hi_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [7:0]  self_id_i = 8'h00;
  logic        msg_ready_i = 1'b0;
  logic [31:0] lo_o, hi_o;
  logic        err_o, msg_valid_o, msg_logical_o, msg_level_o, msg_trig_o;
  logic        msg_bcast_o, msg_excl_self_o;
  logic [7:0]  msg_vector_o, msg_dest_o;
  logic [2:0]  msg_mode_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipi_cmd_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_hi_i(wr_hi_i),
    .wr_data_i(wr_data_i), .self_id_i(self_id_i), .lo_o(lo_o), .hi_o(hi_o),
    .err_o(err_o), .msg_valid_o(msg_valid_o), .msg_ready_i(msg_ready_i),
    .msg_vector_o(msg_vector_o), .msg_mode_o(msg_mode_o),
    .msg_logical_o(msg_logical_o), .msg_level_o(msg_level_o),
    .msg_trig_o(msg_trig_o), .msg_dest_o(msg_dest_o),
    .msg_bcast_o(msg_bcast_o), .msg_excl_self_o(msg_excl_self_o)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(bit hi, logic [31:0] d);
    wr_en_i = 1'b1; wr_hi_i = hi; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wr_hi_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R1 reset state
    check("R1 lo", lo_o, 0);
    check("R1 hi", hi_o, 0);
    check("R1 err", {31'b0, err_o}, 0);
    check("R1 valid", {31'b0, msg_valid_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2 layout: all ones, reserved mode 111 -> R5 error
    wr(1, 32'hFFFF_FFFF);
    check("R2 hi mask", hi_o, 32'hFF00_0000);
    wr(0, 32'hFFFF_FFFF);
    check("R2 lo mask", lo_o, 32'h000C_CFFF);
    check("R5 err", {31'b0, err_o}, 1);
    check("R5 no msg", {31'b0, msg_valid_o}, 0);

    for (int m = 0; m < 8; m++)
      for (int lv = 0; lv < 2; lv++)
        for (int tg = 0; tg < 2; tg++)
          for (int sh = 0; sh < 4; sh++)
            for (int dm = 0; dm < 2; dm++) begin
              automatic logic [7:0]  idx  = 8'({m[2:0], lv[0], tg[0], sh[1:0], dm[0]});
              automatic logic [7:0]  vec  = idx ^ 8'hA5;
              automatic logic [7:0]  dfld = idx * 8'd37 + 8'd11;
              automatic logic [31:0] lo_w = {12'hABC, sh[1:0], 2'b11, tg[0], lv[0], 1'b1,
                                             1'b1, dm[0], m[2:0], vec};
              automatic bit rsv  = (m == 3) || (m == 7);
              automatic bit bad  = rsv || (lv == 0 && !(m == 5 && tg == 1));
              automatic logic [7:0] e_vec = (m == 2 || m == 4 || m == 5) ? 8'h00 : vec;
              automatic bit e_trg = (m == 1) ? tg[0] : (m == 5 && lv == 0);
              automatic logic [7:0] e_dst;
              automatic logic [31:0] e_lo;
              self_id_i = ~idx;
              if (sh == 0) e_dst = dm ? dfld : {4'h0, dfld[3:0]};
              else if (sh == 1) e_dst = ~idx;
              else e_dst = 8'hFF;
              e_lo = {12'h000, sh[1:0], 2'b00, tg[0], lv[0], 1'b0, !bad, dm[0], m[2:0], vec};

              wr(1, {dfld, 24'h5A5A5A});
              wr(0, lo_w);
              // R5/R7/R12: error reflects this launch only
              check(bad ? "R7 R5 reject" : "R12 accept", {31'b0, err_o}, 32'(bad));
              check("R9 valid", {31'b0, msg_valid_o}, 32'(!bad));
              check("R2 readback", lo_o, e_lo);
              if (!bad) begin
                check("R8 vector", 32'(msg_vector_o), 32'(e_vec));
                check("R6 trigger", {31'b0, msg_trig_o}, 32'(e_trg));
                check("R7 level", {31'b0, msg_level_o}, 32'(lv));
                check("R4 R3 dest", 32'(msg_dest_o), 32'(e_dst));
                check("R3 bcast", {30'b0, msg_excl_self_o, msg_bcast_o},
                      {30'b0, sh == 3, sh[1]});
                check("R9 mode", 32'(msg_mode_o), 32'(m));
                check("R9 logical", {31'b0, msg_logical_o}, 32'(dm));
                @(negedge clk);
                wr(0, ~lo_w);
                check("R10 lo", lo_o, e_lo);
                check("R10 err", {31'b0, err_o}, 0);
                check("R9 hold", {31'b0, msg_valid_o}, 1);
                check("R9 hold dest", 32'(msg_dest_o), 32'(e_dst));
                msg_ready_i = 1'b1;
                @(negedge clk);
                msg_ready_i = 1'b0;
                check("R9 drop", {31'b0, msg_valid_o}, 0);
                check("R9 busy bit", 32'(lo_o[12]), 0);
                @(negedge clk);
                check("R11 no resend", {31'b0, msg_valid_o}, 0);
              end
            end
    finish_run();
  end
endmodule